// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This unit owns the program counter of a simple in-order core whose control transfers all have one delay slot. Each cycle that `step` is high, the instruction at `pc` issues. The core supplies that instruction's transfer kind, its offset, index and link-register fields, and its two source operands. The unit decides whether a conditional branch is taken, with operands compared as signed integers. It forms the target in one of three ways: PC-relative, absolute within the 256 MB region of the slot, or taken from a register. It also reports the link write that goes with the instruction.

A resolved target is held in a one-entry pending stage while the delay-slot instruction issues. It is applied to `pc` only when that slot instruction steps. If a register target has either of its two low bits set, the redirect is replaced by a jump to a fixed fault address. `addrErr` is raised in the cycle after the slot instruction has stepped. Fetching and flushing are left to the surrounding pipeline.

Top module: `npc_unit`

## Requirements
- R1: Reset loads `pc` with `RESET_PC` (default 0x0000_1000), clears the pending stage and holds `addrErr` low. Every value `pc` takes has bits [1:0] equal to zero.
- R2: An instruction of kind NONE (code 0, or any code above 12) that steps outside a delay slot advances `pc` by 4 and raises neither `taken` nor `linkWe`.
- R3: After a stepped transfer, the next stepped instruction is at the old `pc`+4 (the delay slot). The resolved target is loaded into `pc` only when that slot instruction steps. `nextPc` shows, at every cycle, the value `pc` takes at the next stepped edge.
- R4: The branch target is (pc+4) plus the 16-bit offset shifted left by two and sign-extended from 18 bits. Negative offsets move backward.
- R5: Branch conditions use kind codes BEQ=1 (rs==rt), BNE=2 (rs!=rt), BLEZ=3, BGTZ=4, BLTZ=5, BGEZ=6, BLTZAL=7, BGEZAL=8. Codes 3 to 8 compare rs with zero. All comparisons are signed, so 0x8000_0000 is negative. A not-taken branch still has a delay slot and then continues at pc+8.
- R6: J=9 and JAL=10 jump to {bits [31:28] of pc+4, index[25:0], 2'b00}. The region therefore comes from the slot address, not from the jump's own address.
- R7: JR=11 and JALR=12 jump to the value of rs.
- R8: If a JR/JALR target has bits [1:0] not equal to zero, the slot instruction still issues. When it steps, `pc` becomes `FAULT_PC` (default 0x0000_0180), and `addrErr` is high for exactly the following cycle.
- R9: BLTZAL, BGEZAL and JAL write the link value `pc`+8 to register 31, whether or not a branch is taken. `linkWe` is high only in the cycle where the instruction steps.
- R10: JALR writes `pc`+8 to the register named by `linkRd`. When that register is 0, `linkWe` stays low.
- R11: A transfer kind presented in a delay slot is treated as NONE. It is not taken, creates no link write and leaves the pending target in force.
- R12: While `step` is low, `pc` and the pending target hold, and `taken` and `linkWe` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| step | input | 1 | The instruction at `pc` issues this cycle |
| kind | input | 4 | Transfer kind code of the instruction at `pc` |
| offset | input | 16 | Branch word offset |
| index | input | 26 | Jump word index |
| linkRd | input | 5 | Link destination for JALR |
| rsVal | input | 32 | First source operand |
| rtVal | input | 32 | Second source operand |
| pc | output | 32 | Address of the current instruction |
| nextPc | output | 32 | Value `pc` takes at the next stepped edge |
| taken | output | 1 | Current stepped instruction transfers control |
| linkWe | output | 1 | Link write enable |
| linkDst | output | 5 | Link destination register |
| linkVal | output | 32 | Return address |
| addrErr | output | 1 | Misaligned register target fault, one cycle |

## Verification
Each branch condition is driven with operands on both sides of its boundary: zero, small positives, 0x7FFF_FFFF and 0x8000_0000. This shows a signed compare apart from an unsigned one and a strict compare apart from a non-strict one. An absolute jump is placed in the last word of a 256 MB region, so a region taken from the jump's own address gives a different result from one taken from the slot. Transfers placed in slots, stalls inside a slot, a zero offset that branches onto the slot itself, a rd=0 link and both misaligned register jumps show whether the target is applied too early, applied twice or lost.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    XK_NONE   = 4'd0,
    XK_BEQ    = 4'd1,
    XK_BNE    = 4'd2,
    XK_BLEZ   = 4'd3,
    XK_BGTZ   = 4'd4,
    XK_BLTZ   = 4'd5,
    XK_BGEZ   = 4'd6,
    XK_BLTZAL = 4'd7,
    XK_BGEZAL = 4'd8,
    XK_J      = 4'd9,
    XK_JAL    = 4'd10,
    XK_JR     = 4'd11,
    XK_JALR   = 4'd12
  } xferKind_t;

  typedef enum logic [1:0] {
    TGT_REL = 2'd0,
    TGT_ABS = 2'd1,
    TGT_REG = 2'd2
  } tgtSel_t;

  // strobes from control to datapath, already gated by step and slot state
  typedef struct packed {
    logic    isXfer;
    logic    takeIt;
    tgtSel_t tgtSel;
    logic    doLink;
    logic    anyDst;
  } npcStrobe_t;

endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]      kind,
  input  logic            step,
  input  logic            inSlot,
  input  logic [XLEN-1:0] rsVal,
  input  logic [XLEN-1:0] rtVal,
  output npcStrobe_t      strobe
);

  logic live;
  logic rsNeg;
  logic rsZero;
  logic opsEq;
  xferKind_t k;

  assign k      = xferKind_t'(kind);
  assign live   = step && !inSlot;
  assign rsNeg  = $signed(rsVal) < 0;
  assign rsZero = (rsVal == '0);
  assign opsEq  = (rsVal == rtVal);

  always_comb begin
    strobe = '0;
    if (live) begin
      unique case (k)
        XK_BEQ:    begin strobe.isXfer = 1'b1; strobe.takeIt = opsEq; end
        XK_BNE:    begin strobe.isXfer = 1'b1; strobe.takeIt = !opsEq; end
        XK_BLEZ:   begin strobe.isXfer = 1'b1; strobe.takeIt = rsNeg || rsZero; end
        XK_BGTZ:   begin strobe.isXfer = 1'b1; strobe.takeIt = !rsNeg && !rsZero; end
        XK_BLTZ:   begin strobe.isXfer = 1'b1; strobe.takeIt = rsNeg; end
        XK_BGEZ:   begin strobe.isXfer = 1'b1; strobe.takeIt = !rsNeg; end
        XK_BLTZAL: begin strobe.isXfer = 1'b1; strobe.takeIt = rsNeg; strobe.doLink = 1'b1; end
        XK_BGEZAL: begin strobe.isXfer = 1'b1; strobe.takeIt = !rsNeg; strobe.doLink = 1'b1; end
        XK_J:      begin strobe.isXfer = 1'b1; strobe.takeIt = 1'b1; strobe.tgtSel = TGT_ABS; end
        XK_JAL:    begin
          strobe.isXfer = 1'b1; strobe.takeIt = 1'b1; strobe.tgtSel = TGT_ABS;
          strobe.doLink = 1'b1;
        end
        XK_JR:     begin strobe.isXfer = 1'b1; strobe.takeIt = 1'b1; strobe.tgtSel = TGT_REG; end
        XK_JALR:   begin
          strobe.isXfer = 1'b1; strobe.takeIt = 1'b1; strobe.tgtSel = TGT_REG;
          strobe.doLink = 1'b1; strobe.anyDst = 1'b1;
        end
        default:   strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/npc_dpath.sv
module npc_dpath
  import npc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          OFF_W    = 16,
  parameter int          IDX_W    = 26,
  parameter int          RA_W     = 5,
  parameter logic [31:0] RESET_PC = 32'h0000_1000,
  parameter logic [31:0] FAULT_PC = 32'h0000_0180
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             step,
  input  npcStrobe_t       strobe,
  input  logic [OFF_W-1:0] offset,
  input  logic [IDX_W-1:0] index,
  input  logic [RA_W-1:0]  linkRd,
  input  logic [XLEN-1:0]  rsVal,
  output logic             inSlot,
  output logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  nextPc,
  output logic             taken,
  output logic             linkWe,
  output logic [RA_W-1:0]  linkDst,
  output logic [XLEN-1:0]  linkVal,
  output logic             addrErr
);

  localparam int          SEXT_W   = XLEN - OFF_W - 2;
  localparam int          REGION_W = XLEN - IDX_W - 2;
  localparam logic [RA_W-1:0] LINK_REG = '1;

  logic [XLEN-1:0] slotPc;
  logic [XLEN-1:0] relTgt;
  logic [XLEN-1:0] absTgt;
  logic [XLEN-1:0] tgt;
  logic            misalign;

  logic            pendValid;
  logic            pendTake;
  logic            pendErr;
  logic [XLEN-1:0] pendTgt;
  logic            errQ;

  assign slotPc = pc + XLEN'(4);
  assign relTgt = slotPc + {{SEXT_W{offset[OFF_W-1]}}, offset, 2'b00};
  assign absTgt = {slotPc[XLEN-1 -: REGION_W], index, 2'b00};

  always_comb begin
    unique case (strobe.tgtSel)
      TGT_ABS: tgt = absTgt;
      TGT_REG: tgt = rsVal;
      default: tgt = relTgt;
    endcase
  end

  assign misalign = (strobe.tgtSel == TGT_REG) && (rsVal[1:0] != 2'b00);

  always_comb begin
    nextPc = slotPc;
    if (pendValid) begin
      if (pendErr)       nextPc = XLEN'(FAULT_PC);
      else if (pendTake) nextPc = pendTgt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc        <= XLEN'(RESET_PC);
      pendValid <= 1'b0;
      pendTake  <= 1'b0;
      pendErr   <= 1'b0;
      pendTgt   <= '0;
      errQ      <= 1'b0;
    end else begin
      errQ <= step && pendValid && pendErr;
      if (step) begin
        pc <= nextPc;
        if (pendValid) begin
          pendValid <= 1'b0;
        end else if (strobe.isXfer) begin
          pendValid <= 1'b1;
          pendTake  <= strobe.takeIt;
          pendErr   <= misalign;
          pendTgt   <= tgt;
        end
      end
    end
  end

  assign inSlot  = pendValid;
  assign addrErr = errQ;
  assign taken   = strobe.isXfer && strobe.takeIt;
  assign linkDst = strobe.anyDst ? linkRd : LINK_REG;
  assign linkWe  = strobe.doLink && (linkDst != '0);
  assign linkVal = pc + XLEN'(8);

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          OFF_W    = 16,
  parameter int          IDX_W    = 26,
  parameter int          RA_W     = 5,
  parameter logic [31:0] RESET_PC = 32'h0000_1000,
  parameter logic [31:0] FAULT_PC = 32'h0000_0180
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             step,
  input  logic [3:0]       kind,
  input  logic [OFF_W-1:0] offset,
  input  logic [IDX_W-1:0] index,
  input  logic [RA_W-1:0]  linkRd,
  input  logic [XLEN-1:0]  rsVal,
  input  logic [XLEN-1:0]  rtVal,
  output logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  nextPc,
  output logic             taken,
  output logic             linkWe,
  output logic [RA_W-1:0]  linkDst,
  output logic [XLEN-1:0]  linkVal,
  output logic             addrErr
);

  npcStrobe_t strobe;
  logic       inSlot;

  npc_ctrl #(.XLEN(XLEN)) ctrl (
    .kind   (kind),
    .step   (step),
    .inSlot (inSlot),
    .rsVal  (rsVal),
    .rtVal  (rtVal),
    .strobe (strobe)
  );

  npc_dpath #(
    .XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W), .RA_W(RA_W),
    .RESET_PC(RESET_PC), .FAULT_PC(FAULT_PC)
  ) dpath (
    .clk     (clk),
    .rstN    (rstN),
    .step    (step),
    .strobe  (strobe),
    .offset  (offset),
    .index   (index),
    .linkRd  (linkRd),
    .rsVal   (rsVal),
    .inSlot  (inSlot),
    .pc      (pc),
    .nextPc  (nextPc),
    .taken   (taken),
    .linkWe  (linkWe),
    .linkDst (linkDst),
    .linkVal (linkVal),
    .addrErr (addrErr)
  );

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int          XLEN     = 32,
  parameter int          RA_W     = 5,
  parameter logic [31:0] FAULT_PC = 32'h0000_0180
) (
  input logic            clk,
  input logic            rstN,
  input logic            step,
  input logic [XLEN-1:0] pc,
  input logic            taken,
  input logic            linkWe,
  input logic [RA_W-1:0] linkDst,
  input logic            addrErr
);

  // R1
  pc_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    pc[1:0] == 2'b00);

  // R12
  stall_holds_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    !step |=> $stable(pc));

  // R3
  slot_follows_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step && taken) |=> (pc == $past(pc) + XLEN'(4)));

  // R11
  no_xfer_in_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step && taken) |=> !taken);

  // R10
  no_link_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> (linkDst != '0));

  // R8
  fault_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> (pc == XLEN'(FAULT_PC)));

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .RA_W(RA_W), .FAULT_PC(FAULT_PC)) chk (
  .clk     (clk),
  .rstN    (rstN),
  .step    (step),
  .pc      (pc),
  .taken   (taken),
  .linkWe  (linkWe),
  .linkDst (linkDst),
  .addrErr (addrErr)
);

// File: tb/npc_unit_test.sv
module npc_unit_test;

  localparam logic [31:0] RST = 32'h0000_1000;
  localparam logic [31:0] FLT = 32'h0000_0180;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        step = 1'b0;
  logic [3:0]  kind = 4'd0;
  logic [15:0] offset = '0;
  logic [25:0] index = '0;
  logic [4:0]  linkRd = '0;
  logic [31:0] rsVal = '0;
  logic [31:0] rtVal = '0;
  logic [31:0] pc, nextPc, linkVal;
  logic        taken, linkWe, addrErr;
  logic [4:0]  linkDst;

  int compared = 0;
  int mismatched = 0;

  // reference state
  logic [31:0] mPc;
  bit          mPend, mTake, mErrPend, mErrOut;
  logic [31:0] mTgt;

  always #10 clk = ~clk;

  npc_unit uut (
    .clk(clk), .rstN(rstN), .step(step), .kind(kind), .offset(offset),
    .index(index), .linkRd(linkRd), .rsVal(rsVal), .rtVal(rtVal),
    .pc(pc), .nextPc(nextPc), .taken(taken), .linkWe(linkWe),
    .linkDst(linkDst), .linkVal(linkVal), .addrErr(addrErr)
  );

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic doStep(string tag, int k, bit st, logic [31:0] rs = 0,
                        logic [31:0] rt = 0, logic [15:0] off = 0,
                        logic [25:0] idx = 0, logic [4:0] rd = 0);
    bit          cond, xfer, lnk, err;
    logic [31:0] tgt, expNext;
    logic [4:0]  dst;
    @(negedge clk);
    step = st; kind = 4'(k); rsVal = rs; rtVal = rt; offset = off; index = idx; linkRd = rd;
    #2;
    xfer = 0; cond = 0; lnk = 0; dst = 5'd31; err = 0; tgt = 0;
    if (st && !mPend && k >= 1 && k <= 12) begin
      xfer = 1;
      case (k)
        1: cond = (rs == rt);
        2: cond = (rs != rt);
        3: cond = ($signed(rs) <= 0);
        4: cond = ($signed(rs) > 0);
        5, 7: cond = ($signed(rs) < 0);
        default: cond = ($signed(rs) >= 0);
      endcase
      if (k >= 9) cond = 1;
      lnk = (k == 7 || k == 8 || k == 10 || k == 12);
      if (k == 12) dst = rd;
      if (k <= 8) tgt = mPc + 4 + {{14{off[15]}}, off, 2'b00};
      else if (k <= 10) tgt = {mPc[31:28] + ((mPc + 4) >> 28) - mPc[31:28], idx, 2'b00};
      else begin tgt = rs; err = (rs % 4) != 0; end
      if (dst == 0) lnk = 0;
    end
    expNext = mPc + 4;
    if (mPend) expNext = mErrPend ? FLT : (mTake ? mTgt : mPc + 4);
    cmp(tag, "pc", pc, mPc);
    cmp(tag, "nextPc", nextPc, expNext);
    cmp(tag, "taken", 32'(taken), 32'(xfer && cond));
    cmp(tag, "linkWe", 32'(linkWe), 32'(lnk));
    if (lnk) begin
      cmp(tag, "linkDst", 32'(linkDst), 32'(dst));
      cmp(tag, "linkVal", linkVal, mPc + 8);
    end
    cmp(tag, "addrErr", 32'(addrErr), 32'(mErrOut));
    @(posedge clk);
    #1;
    mErrOut = st && mPend && mErrPend;
    if (st) begin
      mPc = expNext;
      if (mPend) mPend = 0;
      else if (xfer) begin mPend = 1; mTake = cond; mTgt = tgt; mErrPend = err; end
    end
  endtask

  initial begin
    #4_000_000;
    mismatched++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    mPc = RST; mPend = 0; mTake = 0; mErrPend = 0; mErrOut = 0; mTgt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    cmp("R1", "reset pc", pc, RST);
    cmp("R1", "reset addrErr", 32'(addrErr), 0);
    // R2 plain flow, including an unused kind code
    doStep("R2", 0, 1);
    doStep("R2", 14, 1);
    // R4 R5 BEQ taken forward, slot, then not-taken BEQ
    doStep("R4", 1, 1, 7, 7, 16'd4);
    doStep("R3", 0, 1);
    doStep("R5", 1, 1, 5, 6, 16'd9);
    // R11 a branch placed in the slot is ignored
    doStep("R11", 2, 1, 1, 2, 16'd40);
    // R5 signed BLEZ on 0x80000000, negative offset; R12 stall in slot
    doStep("R5", 3, 1, 32'h8000_0000, 0, 16'hFFFE);
    doStep("R12", 0, 0);
    doStep("R12", 12, 0, 32'h0000_2000, 0, 0, 0, 5'd3);
    doStep("R3", 0, 1);
    doStep("R5", 4, 1, 0);
    doStep("R5", 0, 1);
    doStep("R5", 4, 1, 32'h7FFF_FFFF, 0, 16'd2);
    doStep("R5", 0, 1);
    // R9 linking branches, taken and not taken
    doStep("R9", 7, 1, 1, 0, 16'd8);
    doStep("R9", 0, 1);
    doStep("R9", 8, 1, 0, 0, 16'd3);
    doStep("R9", 0, 1);
    doStep("R5", 5, 1, 32'hFFFF_FFFB, 0, 16'd1);
    doStep("R5", 0, 1);
    // R4 zero offset lands on the slot itself
    doStep("R4", 6, 1, 32'h7FFF_FFFF, 0, 16'd0);
    doStep("R4", 0, 1);
    doStep("R4", 0, 1);
    doStep("R5", 2, 1, 1, 2, 16'd2);
    doStep("R5", 0, 1);
    // R7 register jump to the last word of a region; R6 region from slot
    doStep("R7", 11, 1, 32'h1FFF_FFF8);
    doStep("R7", 0, 1);
    doStep("R7", 0, 1);
    doStep("R6", 9, 1, 0, 0, 0, 26'h40);
    doStep("R6", 0, 1);
    doStep("R6", 10, 1, 0, 0, 0, 26'h5);
    doStep("R9", 0, 1);
    // R10 JALR to register 0 and to register 5
    doStep("R10", 12, 1, 32'h0000_3000, 0, 0, 0, 5'd0);
    doStep("R10", 0, 1);
    doStep("R10", 12, 1, 32'h0000_4000, 0, 0, 0, 5'd5);
    doStep("R10", 0, 1);
    // R8 misaligned targets fault after the slot, with stall in slot
    doStep("R8", 11, 1, 32'h0000_5002);
    doStep("R8", 0, 0);
    doStep("R8", 0, 1);
    doStep("R8", 0, 1);
    doStep("R8", 12, 1, 32'h0000_6001, 0, 0, 0, 5'd7);
    doStep("R8", 0, 1);
    doStep("R8", 0, 0);
    doStep("R2", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule